// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command, bank and address pins of a four-bank single-data-rate SDRAM from reset onward and walks the device through its mandatory start-up ritual. Clock enable stays high throughout, and the data mask stays high until start-up is over. For a stabilization interval set in nanoseconds, the block drives only no-operation commands. It then closes every bank with one precharge, issues a programmable number of auto-refresh commands (never fewer than eight), and writes a fixed mode word into the device's mode register. Each step waits out its recovery time with no-operations. When the last wait ends, the block raises `init_done`.

Once `init_done` is high, the block acts as a registered pass-through for a single command stream from the memory controller. That stream uses a valid/ready handshake. `req_ready` equals `init_done`, so the only back-pressure is the start-up period. While `req_ready` is low, requests are dropped and not queued. A request is accepted on any rising edge where both `req_valid` and `req_ready` are high. The requester may change or withdraw a request while `req_ready` is low.

Top module: `sdram_init_seq`

## Requirements
- R1: `sd_cke` is high in every cycle. `sd_dqm` is all ones while `init_done` is low and all zeros while `init_done` is high.
- R2: Define WAIT_CYC = ceil(WAIT_NS*1000 / CLK_PERIOD_PS). After reset is released, the pins carry only NOP for the first WAIT_CYC rising edges. The precharge appears on the pins right after rising edge number WAIT_CYC.
- R3: The command is carried on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}. The codes are NOP = 4'b0111, PRECHARGE = 4'b0010, AUTO REFRESH = 4'b0001 and LOAD MODE = 4'b0000. Before `init_done`, no other code appears.
- R4: The start-up precharge drives address bit 10 high, all other address bits low, and bank 00, which selects all banks.
- R5: max(REF_CNT, 8) auto-refresh commands follow the precharge. The first comes T_RP_CYC edges after the precharge, and each later one comes T_RC_CYC edges after the one before. Every cycle between these commands is NOP with a zero address.
- R6: LOAD MODE comes T_RC_CYC edges after the last refresh, with sd_addr = MODE_WORD and sd_ba = 00.
- R7: `init_done` rises T_MRD_CYC edges after LOAD MODE, with NOP on the pins in that cycle. It stays high until reset.
- R8: While `init_done` is low, `req_ready` is low and `req_valid`/`req_cmd`/`req_ba`/`req_addr` have no effect on any output.
- R9: While `init_done` is high, `req_ready` is high. A request present at a rising edge appears on the command, bank and address pins in the following cycle. When no request is valid, the pins carry NOP with a zero bank and a zero address.
- R10: An active-low `rst_n` asynchronously forces NOP, a zero address, `init_done` low and the data mask high. On release, the whole sequence restarts from the stabilization wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Controller command valid |
| req_ready | output | 1 | Command accepted (equals init_done) |
| req_cmd | input | 4 | Controller command {cs_n, ras_n, cas_n, we_n} |
| req_ba | input | BA_W | Controller bank address |
| req_addr | input | ROW_W | Controller address |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BA_W | SDRAM bank address |
| sd_addr | output | ROW_W | SDRAM address bus |
| sd_dqm | output | DQM_W | SDRAM data mask |
| init_done | output | 1 | Start-up sequence finished |

## Verification
The assertions assume that `rst_n` is the only thing that can restart the sequence. They also assume that requests can reach the pins only once `init_done` is high, so every ordering check is limited to the cycles before `init_done`. They make no assumption about the request inputs. To show that the block ignores requests during start-up, the stimulus drives random valid commands, banks and addresses in every cycle, including codes that collide with the start-up commands. Reset is asserted in the middle of the refresh phase and again after completion, both times on the falling edge, so each release is well clear of a rising edge.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_WAIT, ST_PRE, ST_REF, ST_MRS, ST_DONE
  } init_state_e;

  typedef enum logic [2:0] {
    SEL_NOP, SEL_PRE, SEL_REF, SEL_MRS, SEL_PASS
  } cmd_sel_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  localparam int AP_BIT = 10;
  localparam int MIN_REFRESHES = 8;

  function automatic int cyc_ceil(input int wait_ns, input int period_ps);
    return (wait_ns * 1000 + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int TMR_W = 16,
  parameter logic [TMR_W-1:0] INIT_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= INIT_VAL;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int TMR_W     = 16,
  parameter int REFS      = 8,
  parameter int REF_W     = 4,
  parameter int T_RP_CYC  = 3,
  parameter int T_RC_CYC  = 9,
  parameter int T_MRD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expired,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output cmd_sel_e         sel,
  output logic             done
);

  init_state_e state_q, state_d;
  logic [REF_W-1:0] refs_q, refs_d;

  always_comb begin
    state_d  = state_q;
    refs_d   = refs_q;
    sel      = SEL_NOP;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_q == ST_DONE) begin
      sel = SEL_PASS;
    end else if (expired) begin
      unique case (state_q)
        ST_WAIT: begin
          sel      = SEL_PRE;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(T_RP_CYC - 1);
          state_d  = ST_PRE;
        end
        ST_PRE: begin
          sel      = SEL_REF;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(T_RC_CYC - 1);
          refs_d   = REF_W'(1);
          state_d  = ST_REF;
        end
        ST_REF: begin
          tmr_load = 1'b1;
          if (refs_q == REF_W'(REFS)) begin
            sel     = SEL_MRS;
            tmr_val = TMR_W'(T_MRD_CYC - 1);
            state_d = ST_MRS;
          end else begin
            sel     = SEL_REF;
            tmr_val = TMR_W'(T_RC_CYC - 1);
            refs_d  = refs_q + 1'b1;
          end
        end
        ST_MRS:  state_d = ST_DONE;
        default: state_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      refs_q  <= '0;
    end else begin
      state_q <= state_d;
      refs_q  <= refs_d;
    end
  end

  assign done = (state_q == ST_DONE);

endmodule

// File: rtl/sdram_cmd_out.sv
module sdram_cmd_out
  import sdram_init_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int BA_W  = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_sel_e         sel,
  input  logic             req_valid,
  input  logic [3:0]       req_cmd,
  input  logic [BA_W-1:0]  req_ba,
  input  logic [ROW_W-1:0] req_addr,
  output logic [3:0]       cmd,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr
);

  logic [3:0]       cmd_d;
  logic [BA_W-1:0]  ba_d;
  logic [ROW_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    unique case (sel)
      SEL_PRE: begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
      end
      SEL_REF: cmd_d = CMD_REF;
      SEL_MRS: begin
        cmd_d  = CMD_MRS;
        addr_d = MODE_WORD;
      end
      SEL_PASS: begin
        if (req_valid) begin
          cmd_d  = req_cmd;
          ba_d   = req_ba;
          addr_d = req_addr;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
    end else begin
      cmd  <= cmd_d;
      ba   <= ba_d;
      addr <= addr_d;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int WAIT_NS       = 200000,
  parameter int T_RP_CYC      = 3,
  parameter int T_RC_CYC      = 9,
  parameter int T_MRD_CYC     = 2,
  parameter int REF_CNT       = 8,
  parameter int ROW_W         = 13,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = 'h032
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_cmd,
  input  logic [BA_W-1:0]  req_ba,
  input  logic [ROW_W-1:0] req_addr,
  output logic             sd_cke,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_addr,
  output logic [DQM_W-1:0] sd_dqm,
  output logic             init_done
);

  localparam int WAIT_CYC = cyc_ceil(WAIT_NS, CLK_PERIOD_PS);
  localparam int REFS     = (REF_CNT < MIN_REFRESHES) ? MIN_REFRESHES : REF_CNT;
  localparam int REF_W    = $clog2(REFS + 1);
  localparam int TMAX_A   = (WAIT_CYC > T_RC_CYC) ? WAIT_CYC : T_RC_CYC;
  localparam int TMAX_B   = (T_RP_CYC > T_MRD_CYC) ? T_RP_CYC : T_MRD_CYC;
  localparam int TMAX     = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TMR_W    = $clog2(TMAX + 1);
  localparam logic [TMR_W-1:0] WAIT_INIT = TMR_W'(WAIT_CYC - 1);

  logic             expired;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  cmd_sel_e         sel;
  logic             done;
  logic [3:0]       cmd;

  sdram_init_timer #(.TMR_W(TMR_W), .INIT_VAL(WAIT_INIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(expired)
  );

  sdram_init_fsm #(
    .TMR_W(TMR_W), .REFS(REFS), .REF_W(REF_W),
    .T_RP_CYC(T_RP_CYC), .T_RC_CYC(T_RC_CYC), .T_MRD_CYC(T_MRD_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .expired(expired), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .sel(sel), .done(done)
  );

  sdram_cmd_out #(.ROW_W(ROW_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)) u_out (
    .clk(clk), .rst_n(rst_n), .sel(sel), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_ba(req_ba), .req_addr(req_addr),
    .cmd(cmd), .ba(sd_ba), .addr(sd_addr)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke    = 1'b1;
  assign sd_dqm    = {DQM_W{~done}};
  assign init_done = done;
  assign req_ready = done;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
  import sdram_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int WAIT_NS       = 200000,
  parameter int REF_CNT       = 8,
  parameter int ROW_W         = 13,
  parameter int BA_W          = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [BA_W-1:0]  sd_ba,
  input logic [ROW_W-1:0] sd_addr,
  input logic             init_done
);

  localparam int WAIT_CYC = cyc_ceil(WAIT_NS, CLK_PERIOD_PS);
  localparam int REFS     = (REF_CNT < MIN_REFRESHES) ? MIN_REFRESHES : REF_CNT;

  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  int   edges_q;
  int   refs_q;
  logic pre_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_q    <= 0;
      refs_q     <= 0;
      pre_seen_q <= 1'b0;
    end else begin
      if (edges_q < WAIT_CYC) edges_q <= edges_q + 1;
      if (!init_done && cmd == CMD_REF) refs_q <= refs_q + 1;
      if (!init_done && cmd == CMD_PRE) pre_seen_q <= 1'b1;
    end
  end

  a_r2_pre_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == CMD_PRE) |-> edges_q >= WAIT_CYC);

  a_r3_startup_codes: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (cmd == CMD_NOP || cmd == CMD_PRE || cmd == CMD_REF || cmd == CMD_MRS));

  a_r4_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == CMD_PRE) |-> (sd_addr[AP_BIT] && sd_ba == '0));

  a_r5_ref_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == CMD_REF) |-> (pre_seen_q && refs_q < REFS));

  a_r6_mode_after_refs: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == CMD_MRS) |-> (refs_q == REFS && sd_addr == MODE_WORD && sd_ba == '0));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r7_done_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> refs_q == REFS);

endmodule

bind sdram_init_seq sdram_init_chk #(
  .CLK_PERIOD_PS(CLK_PERIOD_PS), .WAIT_NS(WAIT_NS), .REF_CNT(REF_CNT),
  .ROW_W(ROW_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
  .init_done(init_done)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  // 796 ns at 8 ns per cycle = 99.5, rounded up to 100 (R2)
  localparam int W    = 100;
  localparam int TRP  = 3;
  localparam int TRC  = 9;
  localparam int TMRD = 2;
  localparam int NREF = 9;
  localparam logic [12:0] MW = 13'h0A27;
  localparam int P = W;
  localparam int R0 = W + TRP;
  localparam int M = R0 + NREF * TRC;
  localparam int D = M + TMRD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_cmd = 4'h0;
  logic [1:0] req_ba = 2'h0;
  logic [12:0] req_addr = 13'h0;
  logic req_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [1:0] sd_ba, sd_dqm;
  logic [12:0] sd_addr;

  sdram_init_seq #(
    .CLK_PERIOD_PS(8000), .WAIT_NS(796), .T_RP_CYC(TRP), .T_RC_CYC(TRC),
    .T_MRD_CYC(TMRD), .REF_CNT(NREF), .ROW_W(13), .BA_W(2), .DQM_W(2),
    .MODE_WORD(MW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_ba(req_ba), .req_addr(req_addr), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .init_done(init_done)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int n = 0;
  int total = 0;
  logic lv;
  logic [3:0] lc;
  logic [1:0] lb;
  logic [12:0] la;

  always @(posedge clk) begin
    total <= total + 1;
    if (!rst_n) n <= 0; else n <= n + 1;
    lv <= req_valid; lc <= req_cmd; lb <= req_ba; la <= req_addr;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at step %0d: actual %0h expected %0h", tag, what, n, act, exp);
    end
  endtask

  // reference model: expected pins for the cycle after rising edge k
  always @(negedge clk) begin
    int ec, eb, ea, ed;
    string tag;
    ec = 4'b0111; eb = 0; ea = 0; ed = 0;
    if (!rst_n) tag = "R10";
    else if (n < P) tag = "R2";
    else if (n == P) begin tag = "R4"; ec = 4'b0010; ea = 13'h0400; end
    else if (n < M) begin
      tag = "R5";
      if (n >= R0 && (n - R0) % TRC == 0) ec = 4'b0001;
    end
    else if (n == M) begin tag = "R6"; ec = 4'b0000; ea = MW; end
    else if (n <= D) begin tag = "R7"; ed = (n == D); end
    else begin
      tag = "R9"; ed = 1;
      if (lv) begin ec = lc; eb = lb; ea = la; end
    end
    chk(tag, "cmd R3 R8", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, ec);
    chk(tag, "ba", sd_ba, eb);
    chk(tag, "addr", sd_addr, ea);
    chk(tag, "init_done R7", init_done, ed);
    chk(tag, "req_ready R8", req_ready, ed);
    chk("R1", "cke", sd_cke, 1);
    chk("R1", "dqm", sd_dqm, ed ? 0 : 3);
  end

  always @(negedge clk) begin
    #1;
    req_valid = $urandom_range(0, 3) != 0;
    req_cmd   = 4'($urandom);
    req_ba    = 2'($urandom);
    req_addr  = 13'($urandom);
  end

  task automatic run_to(input int k);
    while (n < k) @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(negedge clk); #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    run_to(D + 30);       // full sequence then pass-through (R9)
    pulse_reset();        // reset after completion (R10)
    run_to(140);          // stop mid refresh phase
    pulse_reset();
    run_to(D + 40);       // full restart
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (total > 5000);
    errors++;
    $display("FAIL watchdog expired at step %0d", n);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule